// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Sum Output

This block adds two unsigned operands one bit per clock. While the synchronous, active-high reset is held, both operands are captured into right-shifting registers. Once reset is released, the least significant pair of bits goes first into a four-state Moore machine. That machine stores the running carry and the sum bit for the pair it has just consumed, so each sum bit appears at the machine's output one clock after its operand bits.

A third shift register takes the registered sum bit in at its top end and moves it toward bit 0. A down-counter stops that register once every bit has arrived, and the counter reaching zero raises the done flag. A new reset starts a new addition at any time, including partway through one already running. The width is a parameter and must be at least 2.

Top module: `serial_moore_adder`

## Requirements
- R1: The clock edge at which rst is sampled high clears sumOut to zero and forces done low. Both values hold for as long as rst stays high.
- R2: After rst is released, done stays low for WIDTH clocks and rises on the (WIDTH+1)-th rising edge.
- R3: While done is high, sumOut equals (opA + opB) mod 2^WIDTH, using the opA and opB values sampled on the last edge that had rst high.
- R4: Once done is high, it and sumOut keep their values until rst is asserted again.
- R5: The carry out of the top bit is discarded. For example, all-ones plus one gives zero, and 0x80 plus 0x80 gives zero at the default width.
- R6: Result bits enter at bit WIDTH-1 and move toward bit 0. After j clocks following reset release, with 2 <= j <= WIDTH+1, sumOut[WIDTH-1 : WIDTH-j+1] holds the j-1 lowest bits of the sum. The first bit shifted in is the reset-state output 0, and it is pushed out of bit 0 on the last shift.
- R7: Asserting rst while an addition is still running abandons it. The next result is the sum of the newly loaded operands.
- R8: Changes on opA and opB while rst is low have no effect on the result in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the operands and starts an addition |
| opA | input | WIDTH | First operand, sampled while rst is high |
| opB | input | WIDTH | Second operand, sampled while rst is high |
| sumOut | output | WIDTH | Parallel sum register, valid while done is high |
| done | output | 1 | High once all sum bits have been collected |

## Verification
Two actions can land on the same clock edge. A reset can restart the block while the counter is still shifting, and that edge must win over the shift. The last shift can also coincide with done rising, and the result must be complete on that very edge. The first case is provoked by reasserting reset a few clocks into a running addition. It is judged by done staying low for the full count and the following sum matching only the new operands. The second case is judged by sampling sumOut on the exact clock where done first reads high, and by checking the partly filled upper bits of sumOut on every clock before that.

// File: rtl/sma_pkg.sv
package sma_pkg;

  // Encoding {carry, sumBit}: bit 1 is the stored carry, bit 0 the output bit.
  typedef enum logic [1:0] {
    ST_C0S0 = 2'b00,
    ST_C0S1 = 2'b01,
    ST_C1S0 = 2'b10,
    ST_C1S1 = 2'b11
  } addState_t;

  typedef struct packed {
    logic load;
    logic shiftEn;
  } smaCtrl_t;

endpackage

// File: rtl/sma_control.sv
module sma_control
  import sma_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  output smaCtrl_t ctrl,
  output logic     done
);

  // One extra shift flushes the reset-state output bit out of the low end.
  localparam int STEPS = WIDTH + 1;
  localparam int CW    = $clog2(STEPS + 1);

  logic [CW-1:0] stepCnt;
  logic          running;

  assign running = (stepCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCnt <= CW'(STEPS);
    end else if (running) begin
      stepCnt <= stepCnt - 1'b1;
    end
  end

  always_comb begin
    ctrl.load    = rst;
    ctrl.shiftEn = running & ~rst;
  end

  assign done = ~running;

endmodule

// File: rtl/sma_datapath.sv
module sma_datapath
  import sma_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  smaCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut
);

  logic [WIDTH-1:0] shiftA;
  logic [WIDTH-1:0] shiftB;
  logic [WIDTH-1:0] sumReg;
  addState_t        state;
  addState_t        nextState;
  logic             carryIn;
  logic             bitSum;
  logic             bitCarry;
  logic             serialBit;

  // Operand registers: load during reset, otherwise shift toward bit 0 with zero fill.
  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      shiftA <= opA;
      shiftB <= opB;
    end else begin
      shiftA <= {1'b0, shiftA[WIDTH-1:1]};
      shiftB <= {1'b0, shiftB[WIDTH-1:1]};
    end
  end

  // Full adder on the current bit pair and the carry held in the state.
  always_comb begin
    carryIn   = state[1];
    bitSum    = shiftA[0] ^ shiftB[0] ^ carryIn;
    bitCarry  = (shiftA[0] & shiftB[0]) | (carryIn & (shiftA[0] | shiftB[0]));
    nextState = addState_t'({bitCarry, bitSum});
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      state <= ST_C0S0;
    end else begin
      state <= nextState;
    end
  end

  // Moore output: depends on the present state only.
  assign serialBit = state[0];

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      sumReg <= '0;
    end else if (ctrl.shiftEn) begin
      sumReg <= {serialBit, sumReg[WIDTH-1:1]};
    end
  end

  assign sumOut = sumReg;

endmodule

// File: rtl/serial_moore_adder.sv
module serial_moore_adder
  import sma_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             done
);

  smaCtrl_t ctrl;

  sma_control #(.WIDTH(WIDTH)) u_control (
    .clk  (clk),
    .rst  (rst),
    .ctrl (ctrl),
    .done (done)
  );

  sma_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .sumOut (sumOut)
  );

endmodule

// File: rtl/sma_checker.sv
module sma_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sumOut,
  input logic             done
);

  localparam int STEPS = WIDTH + 1;
  localparam int CW    = $clog2(STEPS + 2);

  logic [CW-1:0]    cyc;
  logic [WIDTH-1:0] refSum;

  // Independent cycle count since reset release and a reference sum.
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= '0;
      refSum <= opA + opB;
    end else if (cyc != CW'(STEPS + 1)) begin
      cyc <= cyc + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!done && sumOut == '0));

  a_r2_done_timing: assert property (@(posedge clk) disable iff (rst)
    done == (cyc >= CW'(STEPS)));

  a_r3_sum_correct: assert property (@(posedge clk) disable iff (rst)
    done |-> (sumOut == refSum));

  a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r4_sum_frozen: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(sumOut));

endmodule

bind serial_moore_adder sma_checker #(.WIDTH(WIDTH)) u_sma_checker (
  .clk    (clk),
  .rst    (rst),
  .opA    (opA),
  .opB    (opB),
  .sumOut (sumOut),
  .done   (done)
);

// File: tb/tb_serial_moore_adder.sv
`timescale 1ns/1ps
module tb_serial_moore_adder;

  localparam int W  = 8;
  localparam int W4 = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst  = 1'b1;
  logic [W-1:0] opA  = '0;
  logic [W-1:0] opB  = '0;
  logic [W-1:0] sum;
  logic         done;

  logic          rst4 = 1'b1;
  logic [W4-1:0] a4   = '0;
  logic [W4-1:0] b4   = '0;
  logic [W4-1:0] sum4;
  logic          done4;

  serial_moore_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .sumOut(sum), .done(done));

  serial_moore_adder #(.WIDTH(W4)) dut4 (
    .clk(clk), .rst(rst4), .opA(a4), .opB(b4), .sumOut(sum4), .done(done4));

  int  checks   = 0;
  int  errors   = 0;
  int  expQ[$];
  bit  seen     = 1'b0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when done first reads high.
  always @(negedge clk) begin
    #1;
    if (rst) begin
      seen = 1'b0;
    end else if (done && !seen) begin
      seen = 1'b1;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected result", int'(sum), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(int'(sum) == e, "R3 scoreboard", int'(sum), e);
      end
    end
  end

  task automatic startOp(input int a, input int b);
    @(negedge clk);
    opA = W'(a);
    opB = W'(b);
    rst = 1'b1;
    @(negedge clk);
    check(!done && sum == '0, "R1 cleared after reset edge", int'(sum), 0);
    rst = 1'b0;
  endtask

  task automatic finishOp(input int a, input int b, input bit scramble);
    int exp;
    exp = (a + b) & MASK;
    for (int j = 1; j <= W + 1; j++) begin
      @(negedge clk);
      if (scramble) begin
        opA = W'($urandom);
        opB = W'($urandom);
      end
      check(done == (j == W + 1), "R2 done timing", int'(done), int'(j == W + 1));
      if (j >= 2)
        check((int'(sum) >> (W - j + 1)) == (exp & ((1 << (j - 1)) - 1)),
              "R6 partial fill", int'(sum) >> (W - j + 1), exp & ((1 << (j - 1)) - 1));
    end
    repeat (2) begin
      @(negedge clk);
      check(done && int'(sum) == exp, "R4 result held", int'(sum), exp);
    end
  endtask

  task automatic runOp(input int a, input int b, input bit scramble, input string tag);
    int exp;
    exp = (a + b) & MASK;
    expQ.push_back(exp);
    startOp(a, b);
    finishOp(a, b, scramble);
    if (tag != "") check(int'(sum) == exp, tag, int'(sum), exp);
  endtask

  task automatic run4(input int a, input int b);
    int exp;
    exp = (a + b) & ((1 << W4) - 1);
    @(negedge clk);
    a4   = W4'(a);
    b4   = W4'(b);
    rst4 = 1'b1;
    @(negedge clk);
    rst4 = 1'b0;
    repeat (W4 + 1) @(negedge clk);
    check(done4 && int'(sum4) == exp, "R3 4-bit exhaustive", int'(sum4), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && sum == '0, "R1 initial reset", int'(sum), 0);

    runOp(0, 0, 1'b0, "R3 zero");
    runOp(255, 1, 1'b0, "R5 all-ones plus one");
    runOp(128, 128, 1'b0, "R5 top carry dropped");
    runOp(255, 255, 1'b0, "R3 all-ones pair");
    runOp(8'h55, 8'hAA, 1'b0, "R3 alternating");
    runOp(8'h0F, 8'h01, 1'b1, "R8 inputs ignored");

    // Restart mid-operation.
    startOp(8'h0F, 8'hF0);
    repeat (3) @(negedge clk);
    runOp(8'h7F, 8'h01, 1'b0, "R7 restart");

    for (int i = 0; i < 150; i++) begin
      int ra, rb;
      ra = int'($urandom & MASK);
      rb = int'($urandom & MASK);
      runOp(ra, rb, (i % 2) == 1, (i % 2) == 1 ? "R8 random scrambled" : "");
    end

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(a, b);

    @(negedge clk);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule